// File: doc/BRIEF.md
# Dual-Format Serial Audio Port

This block produces every timing signal of a digital audio link from the chip's master clock: an audio master clock for an oversampling converter, a bit clock and a left/right word select. It sends two stereo output pairs, one on each of two serial data lines, and receives one stereo input pair on a single serial line. One audio frame always lasts 1024 master clocks. A bit period lasts 16 master clocks, so a frame holds 64 bit periods, and each channel gets 32 of them.

Two framings are selectable. In I2S framing the word select is low for the left channel. The most significant bit follows one bit period after each word-select transition, and the word length is 16, 18 or 20 bits. In right-justified framing the word select is high for the left channel. Exactly 16 bits are carried, and the least significant one sits in the last bit period before the next transition. Parallel samples are 20-bit, MSB-aligned words. They are taken once per frame, during a one-cycle load strobe. Each received stereo pair is presented with a one-cycle valid pulse at the start of the following frame.

Top module: `sap_port`

## Requirements
- R1: A frame is exactly 1024 master clocks. `load_o` is high for one cycle in every frame. The transmit words present in that cycle are captured at its closing edge and are sent in the frame that begins on the next cycle.
- R2: `bclk_o` has a period of 16 master clocks. It is low for the first 8 cycles of each bit period and high for the last 8, which gives 64 bit periods per frame, 32 for each channel.
- R3: `mclk_o` has a period of 4 master clocks (2 high, 2 low), which is 256 cycles per frame.
- R4: `ws_o` and `sd_o` change only on the first cycle of a bit period, which is 8 master clocks after the preceding bit-clock rising edge. They hold for 16 cycles, across the rising edge.
- R5: With `fmt_rj_i`=0 (I2S), `ws_o` is 0 during the left half and 1 during the right half. The W-bit word is sent MSB first in bit periods 1..W of its half, taken from sample bits [19:20-W]. `wlen_i` selects W: 00 gives 16, 01 gives 18, 10 and 11 give 20. All other bit periods carry 0.
- R6: With `fmt_rj_i`=1 (right-justified), `ws_o` is 1 during the left half. Sample bits [19:4] are sent MSB first in bit periods 16..31 of the half, so the LSB comes last before the transition. Bit periods 0..15 carry 0, and `wlen_i` has no effect.
- R7: Each output line `sd_o[i]` carries its own left/right pair, `tx_left_i[i]`/`tx_right_i[i]`, independently of the other line.
- R8: `sd_i` is sampled in the cycle in which `bclk_o` first shows high, using the same framing and bit positions as the transmit side. The received words are MSB-aligned, and the bits outside the active word length are zero.
- R9: `rx_valid_o` pulses for one cycle, on the first cycle of each frame. With it, `rx_left_o`/`rx_right_o` change to the pair received in the previous frame, and they hold between pulses.
- R10: During reset and right after it, all outputs are low and the received words are zero. The first frame after reset transmits all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_rj_i | input | 1 | 0 = I2S framing, 1 = right-justified 16-bit framing |
| wlen_i | input | 2 | I2S word length: 00=16, 01=18, 10/11=20 |
| tx_left_i | input | N_TX x SAMPLE_W | Left transmit word for each output line |
| tx_right_i | input | N_TX x SAMPLE_W | Right transmit word for each output line |
| load_o | output | 1 | One-cycle strobe; transmit words are captured at its closing edge |
| mclk_o | output | 1 | Audio master clock, 4 master clocks per period |
| bclk_o | output | 1 | Bit clock, 16 master clocks per period |
| ws_o | output | 1 | Left/right word select |
| sd_o | output | N_TX | Serial output data lines |
| sd_i | input | 1 | Serial input data line |
| rx_left_o | output | SAMPLE_W | Received left word |
| rx_right_o | output | SAMPLE_W | Received right word |
| rx_valid_o | output | 1 | One-cycle pulse when a new received pair is presented |

## Verification
Assertions check these properties on every cycle:
- the bit-clock and audio-master-clock rising edges fall at fixed phases of the frame position;
- word select and serial data move only at bit-period boundaries;
- right-justified framing keeps the leading bit periods at zero;
- the receive valid pulse lasts one cycle, lands on the first cycle of a frame, and is the only time the received words change.

Only the bench scenarios can show the rest:
- which sample bit lands in which bit period for each word length and framing;
- the one-frame latency from the load strobe to the serial line;
- the independence of the two output lines;
- the content of the received words.

// File: rtl/sap_pkg.sv
package sap_pkg;

    // Result of mapping a bit period onto a sample bit.
    typedef struct packed {
        logic       hit;   // this bit period carries a sample bit
        logic [7:0] idx;   // sample bit index (MSB-aligned word)
    } bitsel_t;

    // Active word length for a framing and a length code.
    function automatic int unsigned word_len(input logic rj, input logic [1:0] wcode,
                                             input int unsigned rj_w);
        if (rj) return rj_w;
        case (wcode)
            2'd0:    return 32'd16;
            2'd1:    return 32'd18;
            default: return 32'd20;
        endcase
    endfunction

    // Maps a bit period (slot) inside a channel half onto a sample bit.
    function automatic bitsel_t map_slot(input logic rj, input logic [1:0] wcode,
                                         input int unsigned slot, input int unsigned sample_w,
                                         input int unsigned slots, input int unsigned rj_w);
        bitsel_t     r;
        int unsigned w;
        int unsigned first;
        r = '0;
        w = word_len(rj, wcode, rj_w);
        if (w > sample_w) w = sample_w;
        if (!rj) begin
            // one bit period of delay after the word-select transition
            if (slot >= 32'd1 && slot <= w) begin
                r.hit = 1'b1;
                r.idx = 8'(sample_w - slot);
            end
        end else begin
            // word ends on the last bit period of the half
            first = slots - w;
            if (slot >= first) begin
                r.hit = 1'b1;
                r.idx = 8'(sample_w - 32'd1 - (slot - first));
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sap_timing.sv
module sap_timing #(
    parameter int BIT_LOG2  = 4,
    parameter int SLOT_LOG2 = 5,
    parameter int MCLK_LOG2 = 2,
    localparam int CW = BIT_LOG2 + SLOT_LOG2 + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fmt_rj_i,
    output logic [SLOT_LOG2-1:0] slot_o,
    output logic                 half_o,
    output logic [CW-1:0]        pos_o,
    output logic                 load_o,
    output logic                 mclk_o,
    output logic                 bclk_o,
    output logic                 ws_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;   // frame position being computed
        logic [CW-1:0] pos;   // frame position currently on the pins
        logic          mclk;
        logic          bclk;
        logic          ws;
    } state_t;

    state_t q, d;

    always_comb begin
        d      = q;
        d.cnt  = q.cnt + CW'(1);
        d.pos  = q.cnt;
        d.mclk = q.cnt[MCLK_LOG2-1];
        d.bclk = q.cnt[BIT_LOG2-1];
        d.ws   = q.cnt[CW-1] ^ fmt_rj_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign slot_o = q.cnt[BIT_LOG2 +: SLOT_LOG2];
    assign half_o = q.cnt[CW-1];
    assign pos_o  = q.pos;
    assign load_o = (q.cnt == '1);
    assign mclk_o = q.mclk;
    assign bclk_o = q.bclk;
    assign ws_o   = q.ws;

    // R1: the strobe cycle is followed by the last position of the frame on the pins
    a_r1_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (q.pos == '1));

    // R2: bit clock rises halfway through a bit period
    a_r2_bclk_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.bclk) |-> (q.pos[BIT_LOG2-1:0] == BIT_LOG2'(1 << (BIT_LOG2-1))));

    // R3: audio master clock rises halfway through its period
    a_r3_mclk_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.mclk) |-> (q.pos[MCLK_LOG2-1:0] == MCLK_LOG2'(1 << (MCLK_LOG2-1))));

    // R4: word select moves only on the first cycle of a bit period
    a_r4_ws_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(fmt_rj_i) && !$stable(q.ws)) |-> (q.pos[BIT_LOG2-1:0] == '0));

endmodule

// File: rtl/sap_tx_lane.sv
module sap_tx_lane
    import sap_pkg::*;
#(
    parameter int SAMPLE_W  = 20,
    parameter int BIT_LOG2  = 4,
    parameter int SLOT_LOG2 = 5,
    parameter int RJ_W      = 16,
    localparam int SLOTS    = 1 << SLOT_LOG2,
    localparam int RJ_FIRST = SLOTS - RJ_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fmt_rj_i,
    input  logic [1:0]           wlen_i,
    input  logic                 load_i,
    input  logic [SLOT_LOG2-1:0] slot_i,
    input  logic                 half_i,
    input  logic [BIT_LOG2-1:0]  pos_phase_i,
    input  logic [SLOT_LOG2-1:0] pos_slot_i,
    input  logic [SAMPLE_W-1:0]  left_i,
    input  logic [SAMPLE_W-1:0]  right_i,
    output logic                 sd_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] shl;  // left word of the frame being sent
        logic [SAMPLE_W-1:0] shr;  // right word of the frame being sent
        logic                sd;
    } state_t;

    state_t              q, d;
    bitsel_t             sel;
    logic [SAMPLE_W-1:0] mask;
    logic [SAMPLE_W-1:0] word;

    always_comb begin
        d    = q;
        sel  = map_slot(fmt_rj_i, wlen_i, 32'(slot_i), SAMPLE_W, SLOTS, RJ_W);
        mask = SAMPLE_W'(1) << sel.idx;
        word = half_i ? q.shr : q.shl;
        d.sd = sel.hit & (|(word & mask));
        if (load_i) begin
            d.shl = left_i;
            d.shr = right_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sd_o = q.sd;

    // R4: serial data changes only on the first cycle of a bit period
    a_r4_sd_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(fmt_rj_i) && $stable(wlen_i) && !$stable(q.sd)) |-> (pos_phase_i == '0));

    // R6: leading bit periods of a right-justified half stay at zero
    a_r6_rj_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_rj_i && $stable(fmt_rj_i) && (int'(pos_slot_i) < RJ_FIRST)) |-> !q.sd);

endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
#(
    parameter int SAMPLE_W  = 20,
    parameter int BIT_LOG2  = 4,
    parameter int SLOT_LOG2 = 5,
    parameter int RJ_W      = 16,
    localparam int CW       = BIT_LOG2 + SLOT_LOG2 + 1,
    localparam int SLOTS    = 1 << SLOT_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_rj_i,
    input  logic [1:0]          wlen_i,
    input  logic [CW-1:0]       pos_i,
    input  logic                sd_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] accl;
        logic [SAMPLE_W-1:0] accr;
        logic [SAMPLE_W-1:0] outl;
        logic [SAMPLE_W-1:0] outr;
        logic                valid;
    } state_t;

    state_t              q, d;
    bitsel_t             sel;
    logic [SAMPLE_W-1:0] mask;
    logic [SAMPLE_W-1:0] bitv;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        sel     = map_slot(fmt_rj_i, wlen_i, 32'(pos_i[BIT_LOG2 +: SLOT_LOG2]),
                           SAMPLE_W, SLOTS, RJ_W);
        mask    = SAMPLE_W'(1) << sel.idx;
        bitv    = sd_i ? mask : '0;
        // sample where the bit clock is first seen high
        if (pos_i[BIT_LOG2-1:0] == BIT_LOG2'(1 << (BIT_LOG2-1)) && sel.hit) begin
            if (pos_i[CW-1]) d.accr = (q.accr & ~mask) | bitv;
            else             d.accl = (q.accl & ~mask) | bitv;
        end
        if (pos_i == '1) begin
            d.outl  = q.accl;
            d.outr  = q.accr;
            d.valid = 1'b1;
            d.accl  = '0;
            d.accr  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign left_o  = q.outl;
    assign right_o = q.outr;
    assign valid_o = q.valid;

    // R9: valid is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R9: valid lands on the first cycle of a frame
    a_r9_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> (pos_i == '0));

    // R9: received words change only together with valid
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(q.outl) || !$stable(q.outr)) |-> q.valid);

endmodule

// File: rtl/sap_port.sv
module sap_port #(
    parameter int N_TX      = 2,
    parameter int SAMPLE_W  = 20,
    parameter int BIT_LOG2  = 4,
    parameter int SLOT_LOG2 = 5,
    parameter int MCLK_LOG2 = 2,
    parameter int RJ_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fmt_rj_i,
    input  logic [1:0]                    wlen_i,
    input  logic [N_TX-1:0][SAMPLE_W-1:0] tx_left_i,
    input  logic [N_TX-1:0][SAMPLE_W-1:0] tx_right_i,
    output logic                          load_o,
    output logic                          mclk_o,
    output logic                          bclk_o,
    output logic                          ws_o,
    output logic [N_TX-1:0]               sd_o,
    input  logic                          sd_i,
    output logic [SAMPLE_W-1:0]           rx_left_o,
    output logic [SAMPLE_W-1:0]           rx_right_o,
    output logic                          rx_valid_o
);

    localparam int CW = BIT_LOG2 + SLOT_LOG2 + 1;

    logic [SLOT_LOG2-1:0] slot;
    logic                 half;
    logic [CW-1:0]        pos;
    logic                 load;

    sap_timing #(
        .BIT_LOG2 (BIT_LOG2),
        .SLOT_LOG2(SLOT_LOG2),
        .MCLK_LOG2(MCLK_LOG2)
    ) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_rj_i(fmt_rj_i),
        .slot_o  (slot),
        .half_o  (half),
        .pos_o   (pos),
        .load_o  (load),
        .mclk_o  (mclk_o),
        .bclk_o  (bclk_o),
        .ws_o    (ws_o)
    );

    assign load_o = load;

    for (genvar i = 0; i < N_TX; i++) begin : g_lane
        sap_tx_lane #(
            .SAMPLE_W (SAMPLE_W),
            .BIT_LOG2 (BIT_LOG2),
            .SLOT_LOG2(SLOT_LOG2),
            .RJ_W     (RJ_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .fmt_rj_i   (fmt_rj_i),
            .wlen_i     (wlen_i),
            .load_i     (load),
            .slot_i     (slot),
            .half_i     (half),
            .pos_phase_i(pos[BIT_LOG2-1:0]),
            .pos_slot_i (pos[BIT_LOG2 +: SLOT_LOG2]),
            .left_i     (tx_left_i[i]),
            .right_i    (tx_right_i[i]),
            .sd_o       (sd_o[i])
        );
    end

    sap_rx #(
        .SAMPLE_W (SAMPLE_W),
        .BIT_LOG2 (BIT_LOG2),
        .SLOT_LOG2(SLOT_LOG2),
        .RJ_W     (RJ_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_rj_i(fmt_rj_i),
        .wlen_i  (wlen_i),
        .pos_i   (pos),
        .sd_i    (sd_i),
        .left_o  (rx_left_o),
        .right_o (rx_right_o),
        .valid_o (rx_valid_o)
    );

endmodule

// File: tb/sap_port_tb.sv
`timescale 1ns/1ps
module sap_port_tb;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fmt_rj = 1'b0;
    logic [1:0]       wlen = 2'd0;
    logic [1:0][19:0] txl, txr;
    logic             load, mclk, bclk, ws, sdin;
    logic [1:0]       sdo;
    logic [19:0]      rxl, rxr;
    logic             rxv;

    int nchk = 0;
    int nerr = 0;
    int k    = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sap_port u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_rj_i(fmt_rj), .wlen_i(wlen),
        .tx_left_i(txl), .tx_right_i(txr), .load_o(load), .mclk_o(mclk),
        .bclk_o(bclk), .ws_o(ws), .sd_o(sdo), .sd_i(sdin),
        .rx_left_o(rxl), .rx_right_o(rxr), .rx_valid_o(rxv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, k);
        end
    endtask

    function automatic int wbits(input bit rj, input int wc);
        if (rj) return 16;
        if (wc == 0) return 16;
        if (wc == 1) return 18;
        return 20;
    endfunction

    // Bit expected in a bit period of a half, from R5/R6.
    function automatic logic ebit(input bit rj, input int wc, input int slot, input logic [19:0] w);
        int n;
        n = wbits(rj, wc);
        if (!rj) return (slot >= 1 && slot <= n) ? w[20-slot] : 1'b0;
        return (slot >= 16) ? w[35-slot] : 1'b0;
    endfunction

    function automatic logic [19:0] topbits(input logic [19:0] w, input int n);
        return w & ~(20'hFFFFF >> n);
    endfunction

    function automatic logic [19:0] txw(input int lane, input int side, input int f);
        if (f == 0) return 20'h0;
        return 20'((f * 32'h3B5A7) ^ (lane * 32'h1D3C9) ^ (side * 32'h9C4E1) ^ 32'h5A5A5);
    endfunction

    function automatic logic [19:0] rxw(input int side, input int f);
        return 20'(((f + 1) * 32'h2F1B9) ^ (side * 32'hC3A57) ^ 32'hA5A5A);
    endfunction

    task automatic run_cfg(input bit rj, input int wc);
        int   p, f, slot, half, ph, n;
        logic pws;
        logic [1:0] psd;
        string t;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        fmt_rj = rj;
        wlen   = 2'(wc);
        sdin   = 1'b0;
        for (int l = 0; l < 2; l++) begin
            txl[l] = txw(l, 0, 1);
            txr[l] = txw(l, 1, 1);
        end
        rst_n = 1'b1;
        k = 0;
        // R10: reset state
        chk("R10 load", 32'(load), 0);
        chk("R10 mclk", 32'(mclk), 0);
        chk("R10 bclk", 32'(bclk), 0);
        chk("R10 ws", 32'(ws), 0);
        chk("R10 sd", 32'(sdo), 0);
        chk("R10 rx_valid", 32'(rxv), 0);
        chk("R10 rx_left", 32'(rxl), 0);
        chk("R10 rx_right", 32'(rxr), 0);
        pws = 1'b0;
        psd = 2'b0;
        n = wbits(rj, wc);
        for (int e = 1; e <= 3 * 1024 + 1; e++) begin
            @(posedge clk);
            @(negedge clk);
            k    = e;
            p    = (k - 1) % 1024;
            f    = (k - 1) / 1024;
            slot = (p >> 4) & 31;
            half = (p >> 9) & 1;
            ph   = p & 15;
            chk("R3 mclk", 32'(mclk), 32'((p >> 1) & 1));
            chk("R2 bclk", 32'(bclk), 32'((p >> 3) & 1));
            t = rj ? "R6 ws" : "R5 ws";
            chk(t, 32'(ws), 32'(half ^ int'(rj)));
            for (int l = 0; l < 2; l++) begin
                if (f == 0)      t = "R10 first frame zero";
                else if (l == 1) t = "R7 lane1 data";
                else if (rj)     t = "R6 data";
                else             t = "R5 data";
                chk(t, 32'(sdo[l]), 32'(ebit(rj, wc, slot, txw(l, half, f))));
            end
            chk("R1 load", 32'(load), 32'((k % 1024) == 1023));
            if (ph != 0 && k >= 2) begin
                chk("R4 ws hold", 32'(ws), 32'(pws));
                chk("R4 sd hold", 32'(sdo), 32'(psd));
            end
            if (p == 0 && f >= 1) begin
                chk("R9 valid", 32'(rxv), 1);
                chk("R8 rx left", 32'(rxl), 32'(topbits(rxw(0, f - 1), n)));
                chk("R8 rx right", 32'(rxr), 32'(topbits(rxw(1, f - 1), n)));
            end else begin
                chk("R9 no valid", 32'(rxv), 0);
            end
            pws = ws;
            psd = sdo;
            // drive the next cycle's inputs
            sdin = ebit(rj, wc, slot, rxw(half, f));
            for (int l = 0; l < 2; l++) begin
                txl[l] = txw(l, 0, f + 1);
                txr[l] = txw(l, 1, f + 1);
            end
        end
    endtask

    initial begin
        txl  = '0;
        txr  = '0;
        sdin = 1'b0;
        run_cfg(1'b0, 0);   // I2S 16
        run_cfg(1'b0, 1);   // I2S 18
        run_cfg(1'b0, 2);   // I2S 20
        run_cfg(1'b0, 3);   // I2S 20 via code 11
        run_cfg(1'b1, 2);   // right-justified, length code must be ignored (R6)
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule